// File: doc/BRIEF.md
# Processor Wake-Up Interrupt Sequencer

This block wakes a sleeping processor in a multiprocessor system. On a single start command it issues a fixed train of three inter-processor messages through an interrupt command register: a reset-style INIT message, then two identical start-up messages. The start-up messages carry the page number of the code the woken processor should begin executing. Each message is two 32-bit register writes. The destination half goes first. The low half follows, and writing it launches the message.

After every launch the sequencer polls a delivery-status input. It holds until the interrupt fabric reports that the message has been accepted. It then waits a fixed number of microseconds before the next message. The delays are counted in clock cycles from a cycles-per-microsecond parameter, so a simulation can use a short time base. A start-up address that is not page aligned, or that is not below 1 MB, is refused with a one-cycle error and no bus traffic. The target can be one processor, named by an 8-bit ID, or every processor except the sender.

Top module: `ipi_wake_seq`

## Requirements
- R1: While reset is held, and after it is released, busy, error and done are 0 and no register write is issued until a valid start is accepted.
- R2: An accepted start produces exactly three messages, six writes in all: INIT, then start-up, then a second start-up whose words are identical to the first.
- R3: A start whose address has any bit set in bits 11:0 or at or above bit 20 raises the error output for exactly the cycle after the start. Busy stays 0 and no write is issued.
- R4: For every message the high word (select = 1) is written in the cycle immediately before the low word (select = 0). The high word holds the destination ID in bits 31:24 and zeros elsewhere.
- R5: After a low-word write the block issues no write while delivery status reads 1. It continues in the cycle after the first cycle in which status reads 0.
- R6: Low words have the level bit (bit 14) set to 1, the trigger bit (bit 15) at 0 and delivery status (bit 12) at 0. The delivery mode in bits 10:8 is 5 for INIT and 6 for start-up.
- R7: The vector field (bits 7:0) is 0 for INIT. For start-up it is the start-up address shifted right by 12.
- R8: When the all-but-self flag is set, bits 19:18 of each low word are 2'b11 and the high word is all zeros. Otherwise bits 19:18 are 2'b00.
- R9: The first start-up high-word write follows the INIT low-word write by K + 10·C + 1 cycles. The second follows the first start-up low-word write by K + 200·C + 1 cycles. Here K is the number of cycles delivery status stays 1 and C is CYCLES_PER_US.
- R10: Done is high for exactly one cycle: the cycle after the second start-up message reads status 0. Busy is already 0 in that cycle.
- R11: A start that arrives while busy is ignored. The writes of the running sequence are unchanged, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| dest_id_i | input | 8 | Target processor ID |
| all_but_self_i | input | 1 | Address every processor except the sender |
| start_addr_i | input | ADDR_W | Physical address of the start-up code |
| dlv_status_i | input | 1 | Delivery status read back; 1 while the message is pending |
| reg_wr_o | output | 1 | Command register write strobe |
| reg_sel_o | output | 1 | 1 = high (destination) word, 0 = low (launch) word |
| reg_wdata_o | output | 32 | Command register write data |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | One-cycle pulse: start address refused |
| done_o | output | 1 | One-cycle pulse: sequence complete |

## Verification
A wrong step counter shows at the ports on the next launch. The message is sent with the wrong delivery mode or vector, or the train ends early with done after one or two messages. A corrupted or wrongly loaded delay counter moves the next high-word write off the expected cycle by at least one. The bench catches this on that write, up to 200·C cycles after the acknowledge. A state machine that leaves polling too early writes while status still reads 1, which is visible in the very next cycle.

// File: rtl/ipi_wake_pkg.sv
// Shared definitions for the processor wake-up sequencer.
// Assumes a 32-bit command word with the low-word field layout below.
package ipi_wake_pkg;

    typedef enum logic [2:0] {
        DLV_FIXED   = 3'd0,
        DLV_SMI     = 3'd2,
        DLV_INIT    = 3'd5,
        DLV_STARTUP = 3'd6
    } dlv_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_POLL,
        ST_WAIT
    } seq_state_e;

    localparam int unsigned CMD_W      = 32;
    localparam int unsigned VEC_W      = 8;
    localparam int unsigned ID_W       = 8;
    localparam int unsigned MODE_LSB   = 8;
    localparam int unsigned LEVEL_BIT  = 14;
    localparam int unsigned SHORT_LSB  = 18;
    localparam int unsigned ID_LSB     = 24;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned LOW_MEG    = 20;
    localparam logic [1:0]  SHORT_NONE = 2'b00;
    localparam logic [1:0]  SHORT_ABS  = 2'b11;
    localparam int unsigned LAST_STEP  = 2;

endpackage

// File: rtl/ipi_cmd_builder.sv
// Builds the high (destination) and low (launch) command words.
// Assumes: inputs are held stable by the controller during a message.
module ipi_cmd_builder
    import ipi_wake_pkg::*;
(
    input  logic             is_sipi_i,
    input  logic [VEC_W-1:0] page_i,
    input  logic [ID_W-1:0]  dest_i,
    input  logic             abs_i,
    output logic [CMD_W-1:0] hi_word_o,
    output logic [CMD_W-1:0] lo_word_o
);

    dlv_mode_e mode;

    // Pick delivery mode and assemble both words.
    always_comb begin
        mode      = is_sipi_i ? DLV_STARTUP : DLV_INIT;
        hi_word_o = '0;
        lo_word_o = '0;
        if (!abs_i) begin
            hi_word_o[ID_LSB +: ID_W] = dest_i;
        end
        lo_word_o[VEC_W-1:0]        = is_sipi_i ? page_i : '0;
        lo_word_o[MODE_LSB +: 3]    = mode;
        lo_word_o[LEVEL_BIT]        = 1'b1;
        lo_word_o[SHORT_LSB +: 2]   = abs_i ? SHORT_ABS : SHORT_NONE;
    end

endmodule

// File: rtl/ipi_delay_timer.sv
// Down-counter for the inter-message delays.
// Loading N makes expire_o high in the N-th following cycle; N must be >= 1.
module ipi_delay_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ipi_seq_ctrl.sv
// Controller for the INIT / start-up / start-up train.
// Validates the start address, latches the request, steps through the
// messages, polls delivery status and schedules the delays.
module ipi_seq_ctrl
    import ipi_wake_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SHORT_CYC = 10,
    parameter int unsigned LONG_CYC  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ID_W-1:0]   dest_id_i,
    input  logic              abs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dlv_status_i,
    input  logic              expire_i,
    output seq_state_e        state_o,
    output logic              is_sipi_o,
    output logic [VEC_W-1:0]  page_o,
    output logic [ID_W-1:0]   dest_o,
    output logic              abs_o,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic              err_o,
    output logic              done_o
);

    seq_state_e       state_q;
    logic [1:0]       step_q;
    logic [ID_W-1:0]  dest_q;
    logic             abs_q;
    logic [VEC_W-1:0] page_q;
    logic             err_q;
    logic             done_q;
    logic             addr_ok;
    logic             acked;

    // Address must be page aligned and below 1 MB.
    assign addr_ok = (addr_i[ADDR_W-1:LOW_MEG] == '0) && (addr_i[PAGE_SHIFT-1:0] == '0);
    assign acked   = (state_q == ST_POLL) && !dlv_status_i;

    // Sequencing state, request latch and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            dest_q  <= '0;
            abs_q   <= 1'b0;
            page_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (addr_ok) begin
                            dest_q  <= dest_id_i;
                            abs_q   <= abs_i;
                            page_q  <= addr_i[PAGE_SHIFT +: VEC_W];
                            step_q  <= '0;
                            state_q <= ST_HI;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_HI:   state_q <= ST_LO;
                ST_LO:   state_q <= ST_POLL;
                ST_POLL: begin
                    if (acked) begin
                        if (step_q == 2'(LAST_STEP)) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (expire_i) begin
                        step_q  <= step_q + 1'b1;
                        state_q <= ST_HI;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Start the delay after INIT and after the first start-up message.
    assign tmr_load_o = acked && (step_q != 2'(LAST_STEP));
    assign tmr_val_o  = (step_q == 2'd0) ? CNT_W'(SHORT_CYC) : CNT_W'(LONG_CYC);

    assign state_o   = state_q;
    assign is_sipi_o = (step_q != 2'd0);
    assign page_o    = page_q;
    assign dest_o    = dest_q;
    assign abs_o     = abs_q;
    assign err_o     = err_q;
    assign done_o    = done_q;

endmodule

// File: rtl/ipi_wake_seq.sv
// Top of the processor wake-up sequencer: controller, word builder and
// delay timer. Drives two 32-bit command-register writes per message.
// Assumes dlv_status_i reflects the launched message from the cycle after
// the low-word write.
module ipi_wake_seq
    import ipi_wake_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned CYCLES_PER_US = 100,
    parameter int unsigned INIT_GAP_US   = 10,
    parameter int unsigned SIPI_GAP_US   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        dest_id_i,
    input  logic              all_but_self_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              dlv_status_i,
    output logic              reg_wr_o,
    output logic              reg_sel_o,
    output logic [31:0]       reg_wdata_o,
    output logic              busy_o,
    output logic              err_o,
    output logic              done_o
);

    localparam int unsigned SHORT_CYC = INIT_GAP_US * CYCLES_PER_US;
    localparam int unsigned LONG_CYC  = SIPI_GAP_US * CYCLES_PER_US;
    localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1);

    seq_state_e       state;
    logic             is_sipi;
    logic [VEC_W-1:0] page;
    logic [ID_W-1:0]  dest;
    logic             abs_sel;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             expire;
    logic [CMD_W-1:0] hi_word;
    logic [CMD_W-1:0] lo_word;

    ipi_seq_ctrl #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .dest_id_i    (dest_id_i),
        .abs_i        (all_but_self_i),
        .addr_i       (start_addr_i),
        .dlv_status_i (dlv_status_i),
        .expire_i     (expire),
        .state_o      (state),
        .is_sipi_o    (is_sipi),
        .page_o       (page),
        .dest_o       (dest),
        .abs_o        (abs_sel),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .err_o        (err_o),
        .done_o       (done_o)
    );

    ipi_cmd_builder build_i (
        .is_sipi_i (is_sipi),
        .page_i    (page),
        .dest_i    (dest),
        .abs_i     (abs_sel),
        .hi_word_o (hi_word),
        .lo_word_o (lo_word)
    );

    ipi_delay_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (expire)
    );

    // Drive the command-register write port from the controller state.
    always_comb begin
        reg_wr_o    = (state == ST_HI) || (state == ST_LO);
        reg_sel_o   = (state == ST_HI);
        reg_wdata_o = '0;
        if (state == ST_HI) reg_wdata_o = hi_word;
        if (state == ST_LO) reg_wdata_o = lo_word;
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/ipi_wake_seq_chk.sv
// Port-level protocol checker for ipi_wake_seq, attached by bind.
module ipi_wake_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        reg_wr_o,
    input logic        reg_sel_o,
    input logic [31:0] reg_wdata_o,
    input logic        busy_o,
    input logic        err_o,
    input logic        done_o
);

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !reg_wr_o); // R1
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o); // R3
    AST_HI_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && !reg_sel_o) |-> $past(reg_wr_o && reg_sel_o)); // R4
    AST_NO_WRITE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && !reg_sel_o) |=> !reg_wr_o); // R5
    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && !reg_sel_o) |-> (reg_wdata_o[14] && !reg_wdata_o[15] && !reg_wdata_o[12])); // R6
    AST_ABS_DEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && !reg_sel_o && reg_wdata_o[19:18] == 2'b11) |-> ($past(reg_wdata_o) == 32'd0)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_BUSY_START_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !err_o); // R11

endmodule

bind ipi_wake_seq ipi_wake_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .reg_wr_o    (reg_wr_o),
    .reg_sel_o   (reg_sel_o),
    .reg_wdata_o (reg_wdata_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .done_o      (done_o)
);

// File: tb/ipi_wake_seq_tb_top.sv
`timescale 1ns/1ps
module ipi_wake_seq_tb_top;

    localparam int CPU = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  dest_id_i = '0;
    logic        all_but_self_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        dlv_status_i = 1'b0;
    logic        reg_wr_o;
    logic        reg_sel_o;
    logic [31:0] reg_wdata_o;
    logic        busy_o;
    logic        err_o;
    logic        done_o;

    typedef struct {
        logic        sel;
        logic [31:0] data;
        int          gap;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last_lo = 0;
    int   ack_lat = 1;
    int   ack_cnt = 0;
    int   wd = 0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    ipi_wake_seq #(.CYCLES_PER_US(CPU)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .dest_id_i      (dest_id_i),
        .all_but_self_i (all_but_self_i),
        .start_addr_i   (start_addr_i),
        .dlv_status_i   (dlv_status_i),
        .reg_wr_o       (reg_wr_o),
        .reg_sel_o      (reg_sel_o),
        .reg_wdata_o    (reg_wdata_o),
        .busy_o         (busy_o),
        .err_o          (err_o),
        .done_o         (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Delivery-status stub: pending for ack_lat cycles after each launch.
    always @(negedge clk) begin
        if (rst_n && reg_wr_o && !reg_sel_o) begin
            dlv_status_i = 1'b1;
            ack_cnt = ack_lat;
        end else if (ack_cnt > 0) begin
            ack_cnt--;
            if (ack_cnt == 0) dlv_status_i = 1'b0;
        end
    end

    // Monitor: pop expected writes and compare words, select and spacing.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (reg_wr_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3/R11", "unexpected write", reg_wdata_o, 32'd0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    chk(it.sel == reg_sel_o, it.req, "write select", 32'(reg_sel_o), 32'(it.sel));
                    chk(it.data == reg_wdata_o, it.req, "write data", reg_wdata_o, it.data);
                    if (it.gap != 0)
                        chk(cyc - last_lo == it.gap, "R9", "delay gap", 32'(cyc - last_lo), 32'(it.gap));
                end
                if (!reg_sel_o) last_lo = cyc;
            end
        end
    end

    task automatic push(input logic sel, input logic [31:0] data, input int gap, input string req);
        exp_t it;
        it.sel = sel; it.data = data; it.gap = gap; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic run_seq(input logic [7:0] dest, input bit abs, input logic [31:0] addr,
                           input int k, input bit intrude);
        logic [31:0] hi, lo_init, lo_sipi, sh;
        int n;
        sh      = abs ? (32'h3 << 18) : 32'd0;
        hi      = abs ? 32'd0 : ({24'd0, dest} << 24);
        lo_init = (32'd1 << 14) | (32'd5 << 8) | sh;
        lo_sipi = (32'd1 << 14) | (32'd6 << 8) | sh | (addr >> 12);
        ack_lat = k;
        push(1'b1, hi,      0,                 abs ? "R8" : "R4");
        push(1'b0, lo_init, 0,                 "R6");
        push(1'b1, hi,      k + 10 * CPU + 1,  "R4");
        push(1'b0, lo_sipi, 0,                 "R7");
        push(1'b1, hi,      k + 200 * CPU + 1, "R5");
        push(1'b0, lo_sipi, 0,                 "R2");
        @(negedge clk);
        start_i = 1'b1; dest_id_i = dest; all_but_self_i = abs; start_addr_i = addr;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after start", 32'(busy_o), 32'd1);
        if (intrude) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1; dest_id_i = ~dest; all_but_self_i = ~abs; start_addr_i = 32'h0001_2000;
            @(negedge clk);
            start_i = 1'b0;
            chk(err_o == 1'b0, "R11", "no error on busy start", 32'(err_o), 32'd0);
        end
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, "R10", "done pulse", 32'(done_o), 32'd1);
        chk(busy_o == 1'b0, "R10", "idle with done", 32'(busy_o), 32'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done one cycle", 32'(done_o), 32'd0);
        chk(exp_q.size() == 0, "R2", "all writes seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic bad_addr(input logic [31:0] addr);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = addr; dest_id_i = 8'h11; all_but_self_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b1, "R3", "error raised", 32'(err_o), 32'd1);
        chk(busy_o == 1'b0, "R3", "not busy on error", 32'(busy_o), 32'd0);
        @(negedge clk);
        chk(err_o == 1'b0, "R3", "error one cycle", 32'(err_o), 32'd0);
        repeat (8) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy_o && !reg_wr_o && !err_o && !done_o, "R1", "outputs in reset",
            {28'd0, busy_o, reg_wr_o, err_o, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !reg_wr_o && !err_o && !done_o, "R1", "outputs after reset",
            {28'd0, busy_o, reg_wr_o, err_o, done_o}, 32'd0);

        run_seq(8'h5A, 1'b0, 32'h0009_F000, 2, 1'b0);
        run_seq(8'hC3, 1'b1, 32'h0000_8000, 5, 1'b1);
        run_seq(8'h01, 1'b0, 32'h0000_0000, 1, 1'b0);
        run_seq(8'hFF, 1'b0, 32'h000F_F000, 3, 1'b1);
        bad_addr(32'h0010_0000);
        bad_addr(32'h0009_F001);
        bad_addr(32'h8000_0000);
        run_seq(8'h20, 1'b1, 32'h0004_4000, 1, 1'b0);

        chk(exp_q.size() == 0, "R3", "no stray writes", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule